// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Controller

This block sits between a clocked host and an asynchronous static RAM of 8K words by 9 bits. It takes one word-sized read or write request at a time and turns it into the sequence of chip-enable, output-enable and write-enable levels the memory needs. Each phase lasts a whole number of clock cycles. Every phase length is a parameter, found by rounding the memory's nanosecond limit up to clock periods. The defaults assume a 10 ns clock.

The host side is a valid/ready request channel. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the controller is idle. It drops for the whole access, so the host must hold its request, or change it freely, while ready is low. Nothing is taken until ready returns. The read result comes back as a single-cycle `rsp_valid` pulse with no back-pressure: the host must take it in that cycle.

The memory side drives the address, two chip enables of opposite polarity (active-low `mem_sel_n`, active-high `mem_sel`), an active-low output enable and an active-low write enable. The bidirectional data bus is split into an outgoing word, an incoming word and a driver enable for the pad. The memory is kept deselected whenever no access is running. A deselected turnaround gap follows every access, so the host driver and the memory's output driver never overlap.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: During and after synchronous reset, and whenever idle, the controller drives `mem_sel_n`=1, `mem_sel`=0, `mem_oe_n`=1, `mem_we_n`=1, `mem_dq_oe`=0 and `rsp_valid`=0, with `req_ready`=1.
- R2: A request is accepted only on an edge where `req_valid` and `req_ready` are both high. `req_ready` stays low from the next cycle until the access and its turnaround are over. Request inputs presented while `req_ready` is low have no effect on memory contents.
- R3: A read (`req_write`=0) selects the chip with `mem_oe_n`=0 and `mem_we_n`=1 for exactly READ_CYC cycles, driving the request address.
- R4: `rsp_valid` is high for exactly one cycle, READ_CYC+1 cycles after the accepting edge. `rsp_rdata` is the value of `mem_dq_in` sampled at the end of the last read cycle. It is held unchanged until the next read completes. Writes never raise `rsp_valid`.
- R5: A write (`req_write`=1) selects the chip for WSETUP_CYC cycles with both strobes high. It then holds `mem_we_n`=0 for exactly RELEASE_CYC+DATA_CYC cycles, keeping `mem_oe_n`=1 throughout.
- R6: `mem_dq_oe` is high only during the last DATA_CYC cycles of the write-enable pulse, driving the request data. It falls on the same edge on which `mem_we_n` rises.
- R7: `mem_dq_oe` is never high while the memory may drive the bus (chip selected, `mem_oe_n`=0, `mem_we_n`=1), and never high while `mem_we_n` is high.
- R8: After every access, the chip is deselected for TURN_CYC cycles before `req_ready` returns. A read therefore keeps ready low for READ_CYC+TURN_CYC cycles, and a write for WSETUP_CYC+RELEASE_CYC+DATA_CYC+TURN_CYC cycles.
- R9: `mem_addr` does not change while the chip stays selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (13) | Word address |
| req_wdata | input | DATA_W (9) | Write data |
| rsp_valid | output | 1 | One-cycle read-data strobe |
| rsp_rdata | output | DATA_W (9) | Last read word |
| mem_addr | output | ADDR_W (13) | Memory address bus |
| mem_sel_n | output | 1 | Active-low chip enable |
| mem_sel | output | 1 | Active-high chip enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dq_out | output | DATA_W (9) | Data toward the memory |
| mem_dq_in | input | DATA_W (9) | Data from the memory |
| mem_dq_oe | output | 1 | Pad driver enable for `mem_dq_out` |

## Verification
A phase counter that ends early or late changes the length of the output-enable or write-enable pulse. It also shifts `rsp_valid` and the return of `req_ready`, so the bench catches it at the end of the first access. A wrong sample point shows as a floating-bus value returned in place of stored data on the very first read. A sequencing fault that turns on the data driver too soon shows in the cycle it happens, as overlap with write enable high or with the output enable. A fault that lets a busy-time request through corrupts a word that a later read then returns.

// File: rtl/sram_strobe_pkg.sv
package sram_strobe_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WSETUP,
    ST_WSTROBE,
    ST_TURN
  } ctl_state_e;

endpackage

// File: rtl/sram_strobe_fsm.sv
module sram_strobe_fsm
  import sram_strobe_pkg::*;
#(
  parameter int READ_CYC    = 3,
  parameter int WSETUP_CYC  = 1,
  parameter int RELEASE_CYC = 2,
  parameter int DATA_CYC    = 2,
  parameter int TURN_CYC    = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  input  logic       req_write,
  output ctl_state_e state_o,
  output logic       accept_o,
  output logic       last_read_o,
  output logic       data_win_o
);

  localparam int STROBE_CYC = RELEASE_CYC + DATA_CYC;
  localparam int MAX_A      = (READ_CYC > STROBE_CYC) ? READ_CYC : STROBE_CYC;
  localparam int MAX_B      = (WSETUP_CYC > TURN_CYC) ? WSETUP_CYC : TURN_CYC;
  localparam int MAX_CYC    = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W      = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

  ctl_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] last_idx;
  logic             at_last;

  // index of the final cycle of the current phase
  always_comb begin
    case (state_q)
      ST_READ:    last_idx = CNT_W'(READ_CYC - 1);
      ST_WSETUP:  last_idx = CNT_W'(WSETUP_CYC - 1);
      ST_WSTROBE: last_idx = CNT_W'(STROBE_CYC - 1);
      ST_TURN:    last_idx = CNT_W'(TURN_CYC - 1);
      default:    last_idx = '0;
    endcase
  end

  assign at_last  = (cnt_q == last_idx);
  assign accept_o = req_valid && (state_q == ST_IDLE);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q + 1'b1;
    if (state_q == ST_IDLE) begin
      cnt_d = '0;
      if (req_valid) state_d = req_write ? ST_WSETUP : ST_READ;
    end else if (at_last) begin
      cnt_d = '0;
      case (state_q)
        ST_READ:    state_d = ST_TURN;
        ST_WSETUP:  state_d = ST_WSTROBE;
        ST_WSTROBE: state_d = ST_TURN;
        default:    state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state_o     = state_q;
  assign last_read_o = (state_q == ST_READ) && at_last;
  // host driver waits out the memory's bus-release time inside the strobe
  assign data_win_o  = (state_q == ST_WSTROBE) && (cnt_q >= CNT_W'(RELEASE_CYC));

endmodule

// File: rtl/sram_strobe_drive.sv
module sram_strobe_drive
  import sram_strobe_pkg::*;
(
  input  ctl_state_e state_i,
  input  logic       data_win_i,
  output logic       ready_o,
  output logic       sel_n_o,
  output logic       sel_o,
  output logic       oe_n_o,
  output logic       we_n_o,
  output logic       dq_oe_o
);

  logic selected;

  always_comb begin
    selected = (state_i == ST_READ) || (state_i == ST_WSETUP) ||
               (state_i == ST_WSTROBE);
    ready_o  = (state_i == ST_IDLE);
    sel_n_o  = !selected;
    sel_o    = selected;
    oe_n_o   = (state_i != ST_READ);
    we_n_o   = (state_i != ST_WSTROBE);
    dq_oe_o  = data_win_i;
  end

endmodule

// File: rtl/sram_strobe_datapath.sv
module sram_strobe_datapath #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept_i,
  input  logic              last_read_i,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              rvalid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q   <= '0;
      wdata_q  <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      if (accept_i) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if (last_read_i) rdata_q <= mem_dq_in;
      rvalid_q <= last_read_i;
    end
  end

  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;
  assign rsp_valid  = rvalid_q;
  assign rsp_rdata  = rdata_q;

endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
  import sram_strobe_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int DATA_W      = 9,
  parameter int READ_CYC    = 3,
  parameter int WSETUP_CYC  = 1,
  parameter int RELEASE_CYC = 2,
  parameter int DATA_CYC    = 2,
  parameter int TURN_CYC    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_sel_n,
  output logic              mem_sel,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              mem_dq_oe
);

  ctl_state_e state;
  logic       accept;
  logic       last_read;
  logic       data_win;

  sram_strobe_fsm #(
    .READ_CYC   (READ_CYC),
    .WSETUP_CYC (WSETUP_CYC),
    .RELEASE_CYC(RELEASE_CYC),
    .DATA_CYC   (DATA_CYC),
    .TURN_CYC   (TURN_CYC)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .state_o    (state),
    .accept_o   (accept),
    .last_read_o(last_read),
    .data_win_o (data_win)
  );

  sram_strobe_drive u_drive (
    .state_i   (state),
    .data_win_i(data_win),
    .ready_o   (req_ready),
    .sel_n_o   (mem_sel_n),
    .sel_o     (mem_sel),
    .oe_n_o    (mem_oe_n),
    .we_n_o    (mem_we_n),
    .dq_oe_o   (mem_dq_oe)
  );

  sram_strobe_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .accept_i   (accept),
    .last_read_i(last_read),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .mem_dq_in  (mem_dq_in),
    .mem_addr   (mem_addr),
    .mem_dq_out (mem_dq_out),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata)
  );

endmodule

// File: rtl/sram_strobe_chk.sv
module sram_strobe_chk #(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_sel_n,
  input logic              mem_sel,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              mem_dq_oe
);

  a_r1_idle_deselect: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (mem_sel_n && !mem_sel && mem_oe_n && mem_we_n && !mem_dq_oe));

  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  a_r3_no_strobe_overlap: assert property (@(posedge clk) disable iff (rst)
    !(!mem_oe_n && !mem_we_n));

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  a_r6_release_with_we: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_dq_oe) |-> $rose(mem_we_n));

  a_r7_no_contention: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> (!mem_we_n && mem_oe_n));

  a_r8_gap_before_ready: assert property (@(posedge clk) disable iff (rst)
    $rose(req_ready) |-> $past(mem_sel_n));

  a_r9_addr_stable: assert property (@(posedge clk) disable iff (rst)
    (!mem_sel_n && !$past(mem_sel_n)) |-> $stable(mem_addr));

  a_r1_enables_paired: assert property (@(posedge clk) disable iff (rst)
    mem_sel_n != mem_sel);

endmodule

bind sram_strobe_ctrl sram_strobe_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .rsp_valid(rsp_valid),
  .mem_addr (mem_addr),
  .mem_sel_n(mem_sel_n),
  .mem_sel  (mem_sel),
  .mem_oe_n (mem_oe_n),
  .mem_we_n (mem_we_n),
  .mem_dq_oe(mem_dq_oe)
);

// File: tb/sram_strobe_ctrl_tb.sv
module sram_strobe_ctrl_tb;

  localparam int AW = 6;
  localparam int DW = 9;
  localparam int RD = 3;
  localparam int WS = 1;
  localparam int RL = 2;
  localparam int DC = 2;
  localparam int TC = 2;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst;
  logic          req_valid, req_ready, req_write;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic          rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic [AW-1:0] mem_addr;
  logic          mem_sel_n, mem_sel, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [DW-1:0] mem_dq_out, mem_dq_in;

  int n_chk = 0;
  int n_bad = 0;

  sram_strobe_ctrl #(
    .ADDR_W(AW), .DATA_W(DW), .READ_CYC(RD), .WSETUP_CYC(WS),
    .RELEASE_CYC(RL), .DATA_CYC(DC), .TURN_CYC(TC)
  ) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_sel_n(mem_sel_n), .mem_sel(mem_sel), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in),
    .mem_dq_oe(mem_dq_oe)
  );

  // behavioural memory; 9'h155 stands in for a floating bus
  logic [DW-1:0] model [DEPTH];
  wire mem_drives = !mem_sel_n && mem_sel && !mem_oe_n && mem_we_n;
  assign mem_dq_in = mem_drives ? model[mem_addr] : DW'(9'h155);
  always @(posedge clk)
    if (!mem_sel_n && mem_sel && !mem_we_n && mem_dq_oe) model[mem_addr] <= mem_dq_out;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int p, input int a);
    return (p == 0) ? DW'(a * 37 + 5) : DW'(~(a * 11 + 3));
  endfunction

  // port monitors
  int   we_run = 0, dq_run = 0, oe_run = 0, contention = 0, addr_moves = 0;
  logic sel_prev = 1'b0;
  logic [AW-1:0] addr_prev = '0;
  always @(negedge clk) begin
    if (!rst) begin
      if (mem_dq_oe && (mem_drives || mem_we_n)) contention++;
      if (!mem_sel_n && sel_prev && mem_addr != addr_prev) addr_moves++;
      sel_prev  = !mem_sel_n;
      addr_prev = mem_addr;
      if (!mem_we_n) begin
        we_run++;
        if (mem_dq_oe) dq_run++;
        if (mem_dq_oe && we_run <= RL) check(0, "R6 early driver", we_run, RL + 1);
      end else if (we_run > 0) begin
        check(we_run == RL + DC, "R5 we pulse cycles", we_run, RL + DC);
        check(dq_run == DC, "R6 driver cycles", dq_run, DC);
        check(!mem_dq_oe, "R6 driver off with we", int'(mem_dq_oe), 0);
        we_run = 0;
        dq_run = 0;
      end
      if (!mem_oe_n) oe_run++;
      else if (oe_run > 0) begin
        check(oe_run == RD, "R3 oe pulse cycles", oe_run, RD);
        oe_run = 0;
      end
    end
  end

  task automatic run_op(input logic wr, input int a, input logic [DW-1:0] d,
                        output logic [DW-1:0] rd, output int lat,
                        output int busy, output int pulses);
    int k;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = AW'(a); req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    rd = '0; lat = 0; busy = 0; pulses = 0; k = 1;
    forever begin
      if (rsp_valid) begin
        lat = k; rd = rsp_rdata; pulses++;
      end
      if (req_ready) break;
      busy++;
      @(negedge clk);
      k++;
    end
  endtask

  initial begin
    logic [DW-1:0] rd, last_rd;
    int lat, busy, pulses;
    rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(mem_sel_n && !mem_sel && mem_oe_n && mem_we_n && !mem_dq_oe,
          "R1 reset strobes", {mem_sel_n, mem_sel, mem_oe_n, mem_we_n, mem_dq_oe}, 5'b10110);
    check(req_ready && !rsp_valid, "R1 reset handshake", {req_ready, rsp_valid}, 2'b10);
    rst = 1'b0;
    @(negedge clk);
    check(req_ready && mem_sel_n && !mem_sel, "R1 idle after reset",
          {req_ready, mem_sel_n, mem_sel}, 3'b110);

    last_rd = '0;
    for (int p = 0; p < 2; p++) begin
      for (int a = 0; a < DEPTH; a++) begin
        run_op(1'b1, a, pat(p, a), rd, lat, busy, pulses);
        check(busy == WS + RL + DC + TC, "R8 write busy", busy, WS + RL + DC + TC);
        check(pulses == 0, "R4 no pulse on write", pulses, 0);
      end
      for (int a = 0; a < DEPTH; a++) begin
        run_op(1'b0, a, '0, rd, lat, busy, pulses);
        check(rd == pat(p, a), "R3 read data", int'(rd), int'(pat(p, a)));
        check(lat == RD + 1, "R4 read latency", lat, RD + 1);
        check(pulses == 1, "R4 one pulse", pulses, 1);
        check(busy == RD + TC, "R8 read busy", busy, RD + TC);
        last_rd = rd;
      end
    end

    // R4 hold: a write leaves the last read word untouched
    run_op(1'b1, 0, pat(1, 0), rd, lat, busy, pulses);
    check(rsp_rdata == last_rd, "R4 rdata held", int'(rsp_rdata), int'(last_rd));

    // R2: requests offered while busy are ignored
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = AW'(5); req_wdata = DW'(9'h0F0);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_addr = AW'(9); req_wdata = DW'(9'h1FF);
    for (int k = 0; k < 5; k++) begin
      check(!req_ready, "R2 ready low while busy", int'(req_ready), 0);
      @(negedge clk);
    end
    req_valid = 1'b0;
    while (!req_ready) @(negedge clk);
    run_op(1'b0, 9, '0, rd, lat, busy, pulses);
    check(rd == pat(1, 9), "R2 busy request ignored", int'(rd), int'(pat(1, 9)));
    run_op(1'b0, 5, '0, rd, lat, busy, pulses);
    check(rd == DW'(9'h0F0), "R2 accepted write", int'(rd), 'h0F0);

    repeat (3) @(negedge clk);
    check(contention == 0, "R7 bus contention", contention, 0);
    check(addr_moves == 0, "R9 address moved while selected", addr_moves, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule